// File: doc/BRIEF.md
# PCM-to-PWM H-Bridge Modulator

This block turns unsigned PCM audio samples into two pulse-width modulated drive signals, one for each leg of a full H-bridge. A free-running up-counter sets a fixed switching period. A compare point inside that period sets the pulse width. Leg A is high from the start of the period up to the compare point. Leg B is always the opposite of leg A, so the bridge sees a differential drive from a single compare value.

A sample can arrive at any time. It is scaled to the counter width by dropping its low bits and is stored in a holding register. The holding register is copied into the working compare register only at the period boundary, so a pulse that has already started is never cut short or stretched. In the same cycle the period restarts, the block raises a one-cycle conversion-start pulse. This pulse paces an external sampler, which keeps sampling locked to the switching period.

Top module: `pwm_bridge_mod`

## Requirements
- R1: The counter counts up through 1024 states (0 to 1023) and wraps from 1023 to 0 with no idle cycle, so a period is exactly 1024 clock cycles.
- R2: In each period, leg A is high for exactly C cycles and low for the remaining 1024 - C cycles, where C is the compare value in force for that period. The high cycles come first, starting in the same cycle as the conversion-start pulse.
- R3: Once the first period has started, leg B is the logical inverse of leg A in every cycle.
- R4: The compare value is the 12-bit sample shifted right by two bits: 0xFFF gives 1023, 0x800 or 0x801 gives 512, 0x007 gives 1, and 0x003 gives 0.
- R5: A compare value of 0 keeps leg A low and leg B high for the whole period, because a clear at the compare point wins over a set at the period start.
- R6: A sample written during a period does not change that period's pulse. It takes effect from the next period start.
- R7: When several valid samples arrive within one period, only the last one sets the next period's pulse width.
- R8: The conversion-start output is registered and high for exactly one cycle per period: the first cycle of each period, one clock after the counter reads zero.
- R9: While reset is asserted, both legs and the conversion-start output are low. Both compare registers hold mid-scale (512), so the first period has a pulse width of 512 cycles.
- R10: A period that receives no valid sample repeats the previous pulse width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 12 | Unsigned PCM sample |
| sample_vld_i | input | 1 | Strobe that writes sample_i into the holding register |
| leg_a_o | output | 1 | Bridge leg A drive, high at the start of the period |
| leg_b_o | output | 1 | Bridge leg B drive, inverse of leg A |
| soc_o | output | 1 | One-cycle conversion-start pulse at each period start |

## Verification
The assertions assume that reset is held for at least one clock edge before they are relied on, and that sample_vld_i and sample_i are stable around each rising edge. They also assume that a valid strobe may come at any counter value, including several strobes per period. The bench changes inputs only on falling edges and releases reset on a falling edge. It places every strobe at a fixed offset after a conversion-start pulse, so each write falls inside a known period and never on the boundary cycle. Every period from the first to the last is measured against the pulse width that the driver predicted.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  // Which edge of the period a leg starts on.
  typedef enum logic {
    POL_SET_AT_ZERO   = 1'b0,
    POL_CLEAR_AT_ZERO = 1'b1
  } leg_pol_e;

  // Reduce a sample to the compare width by discarding low bits.
  function automatic logic [31:0] scale_sample(input logic [31:0] s,
                                               input int unsigned drop);
    return s >> drop;
  endfunction

endpackage

// File: rtl/pbm_timebase.sv
module pbm_timebase #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  // Natural binary wrap: terminal count rolls to zero with no idle cycle.
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pbm_duty_regs.sv
module pbm_duty_regs #(
  parameter int SAMPLE_W   = 12,
  parameter int CNT_W      = 10,
  parameter int RESET_DUTY = 512
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_vld_i,
  input  logic                load_i,
  output logic [CNT_W-1:0]    shadow_o,
  output logic [CNT_W-1:0]    active_o,
  output logic [CNT_W-1:0]    eff_o
);

  localparam int SHIFT = SAMPLE_W - CNT_W;
  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RESET_DUTY);

  logic [CNT_W-1:0] shadow_q, active_q, scaled;

  assign scaled = CNT_W'(pbm_pkg::scale_sample(32'(sample_i), SHIFT));

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= RST_VAL;
      active_q <= RST_VAL;
    end else begin
      if (sample_vld_i) shadow_q <= scaled;
      if (load_i)       active_q <= shadow_q;
    end
  end

  // At the boundary the value about to be loaded is already the one compared.
  assign eff_o    = load_i ? shadow_q : active_q;
  assign shadow_o = shadow_q;
  assign active_o = active_q;

endmodule

// File: rtl/pbm_leg.sv
module pbm_leg #(
  parameter pbm_pkg::leg_pol_e POL = pbm_pkg::POL_SET_AT_ZERO
) (
  input  logic clk,
  input  logic rst,
  input  logic zero_evt_i,
  input  logic cmp_evt_i,
  output logic leg_o
);

  localparam logic AT_ZERO = (POL == pbm_pkg::POL_SET_AT_ZERO) ? 1'b1 : 1'b0;

  logic leg_q;

  // The compare event is checked first, so it wins when both events coincide.
  always_ff @(posedge clk) begin
    if (rst)             leg_q <= 1'b0;
    else if (cmp_evt_i)  leg_q <= ~AT_ZERO;
    else if (zero_evt_i) leg_q <= AT_ZERO;
  end

  assign leg_o = leg_q;

endmodule

// File: rtl/pwm_bridge_mod.sv
module pwm_bridge_mod #(
  parameter int SAMPLE_W   = 12,
  parameter int CNT_W      = 10,
  parameter int RESET_DUTY = 2 ** (CNT_W - 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_vld_i,
  output logic                leg_a_o,
  output logic                leg_b_o,
  output logic                soc_o
);

  localparam int NUM_LEGS = 2;

  logic [CNT_W-1:0]    cnt;
  logic                zero_evt;
  logic                cmp_evt;
  logic [CNT_W-1:0]    shadow_cmp, active_cmp, eff_cmp;
  logic [NUM_LEGS-1:0] legs;
  logic                soc_q;

  pbm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk    (clk),
    .rst    (rst),
    .cnt_o  (cnt),
    .zero_o (zero_evt)
  );

  pbm_duty_regs #(
    .SAMPLE_W   (SAMPLE_W),
    .CNT_W      (CNT_W),
    .RESET_DUTY (RESET_DUTY)
  ) u_duty (
    .clk          (clk),
    .rst          (rst),
    .sample_i     (sample_i),
    .sample_vld_i (sample_vld_i),
    .load_i       (zero_evt),
    .shadow_o     (shadow_cmp),
    .active_o     (active_cmp),
    .eff_o        (eff_cmp)
  );

  assign cmp_evt = (cnt == eff_cmp);

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    pbm_leg #(
      .POL(g == 0 ? pbm_pkg::POL_SET_AT_ZERO : pbm_pkg::POL_CLEAR_AT_ZERO)
    ) u_leg (
      .clk        (clk),
      .rst        (rst),
      .zero_evt_i (zero_evt),
      .cmp_evt_i  (cmp_evt),
      .leg_o      (legs[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) soc_q <= 1'b0;
    else     soc_q <= zero_evt;
  end

  assign leg_a_o = legs[0];
  assign leg_b_o = legs[1];
  assign soc_o   = soc_q;

endmodule

// File: rtl/pbm_checker.sv
module pbm_checker #(
  parameter int SAMPLE_W = 12,
  parameter int CNT_W    = 10
) (
  input logic                clk,
  input logic                rst,
  input logic [SAMPLE_W-1:0] sample_i,
  input logic                sample_vld_i,
  input logic                leg_a_o,
  input logic                leg_b_o,
  input logic                soc_o,
  input logic [CNT_W-1:0]    cnt,
  input logic                zero_evt,
  input logic                cmp_evt,
  input logic [CNT_W-1:0]    shadow_cmp,
  input logic [CNT_W-1:0]    active_cmp
);

  localparam int SHIFT = SAMPLE_W - CNT_W;

  logic started;
  always_ff @(posedge clk) begin
    if (rst)        started <= 1'b0;
    else if (soc_o) started <= 1'b1;
  end

  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (&cnt) |=> (cnt == '0));

  a_r2_clear_at_cmp: assert property (@(posedge clk) disable iff (rst)
    cmp_evt |=> !leg_a_o);

  a_r2_set_at_zero: assert property (@(posedge clk) disable iff (rst)
    (zero_evt && !cmp_evt) |=> leg_a_o);

  a_r3_complement: assert property (@(posedge clk) disable iff (rst)
    started |-> (leg_b_o == !leg_a_o));

  a_r6_active_hold: assert property (@(posedge clk) disable iff (rst)
    !zero_evt |=> $stable(active_cmp));

  a_r6_active_load: assert property (@(posedge clk) disable iff (rst)
    zero_evt |=> (active_cmp == $past(shadow_cmp)));

  a_r7_shadow_write: assert property (@(posedge clk) disable iff (rst)
    sample_vld_i |=> (shadow_cmp == CNT_W'($past(sample_i) >> SHIFT)));

  a_r8_soc_follows_zero: assert property (@(posedge clk) disable iff (rst)
    zero_evt |=> soc_o);

  a_r8_soc_only_at_zero: assert property (@(posedge clk) disable iff (rst)
    !zero_evt |=> !soc_o);

  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (!leg_a_o && !leg_b_o && !soc_o));

endmodule

bind pwm_bridge_mod pbm_checker #(
  .SAMPLE_W (SAMPLE_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sample_i     (sample_i),
  .sample_vld_i (sample_vld_i),
  .leg_a_o      (leg_a_o),
  .leg_b_o      (leg_b_o),
  .soc_o        (soc_o),
  .cnt          (cnt),
  .zero_evt     (zero_evt),
  .cmp_evt      (cmp_evt),
  .shadow_cmp   (shadow_cmp),
  .active_cmp   (active_cmp)
);

// File: tb/pwm_bridge_mod_bench.sv
module pwm_bridge_mod_bench;

  localparam int PERIOD = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] sample_i = '0;
  logic        sample_vld_i = 1'b0;
  logic        leg_a_o, leg_b_o, soc_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int    duty;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;

  pwm_bridge_mod u_pwm_bridge_mod (
    .clk          (clk),
    .rst          (rst),
    .sample_i     (sample_i),
    .sample_vld_i (sample_vld_i),
    .leg_a_o      (leg_a_o),
    .leg_b_o      (leg_b_o),
    .soc_o        (soc_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Bench-side scaling, written independently of the design's arithmetic.
  function automatic int expect_duty(input int s);
    return s / 4;
  endfunction

  task automatic wait_soc();
    do @(negedge clk); while (soc_o !== 1'b1);
  endtask

  task automatic strobe(input logic [11:0] s);
    sample_i     = s;
    sample_vld_i = 1'b1;
    @(negedge clk);
    sample_vld_i = 1'b0;
  endtask

  // Writes fall inside the current period; the prediction targets the next one.
  task automatic drive_period(input bit write1, input logic [11:0] s1,
                              input bit write2, input logic [11:0] s2,
                              input int exp_duty, input string tag);
    exp_t e;
    wait_soc();
    repeat (100) @(negedge clk);
    if (write1) strobe(s1);
    repeat (300) @(negedge clk);
    if (write2) strobe(s2);
    e.duty = exp_duty;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: measure each period's waveform against the popped expectation.
  int   cyc = 0;
  int   prev_soc = -1;
  int   periods = 0;
  bit   measuring = 1'b0;
  int   idx = 0;
  exp_t cur;
  int   a_bad = -1;
  int   a_bad_val = 0;
  int   b_bad = -1;

  task automatic close_period();
    if (a_bad < 0)
      check(1'b1, cur.tag, "leg A shape", cur.duty, cur.duty);
    else
      check(1'b0, cur.tag, $sformatf("leg A at offset %0d", a_bad),
            a_bad_val, (a_bad < cur.duty) ? 1 : 0);
    check(b_bad < 0, "R3", "leg B inverse mismatch offset", b_bad, -1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        cyc++;
        if (soc_o === 1'b1) begin
          if (prev_soc >= 0)
            check(cyc - prev_soc == PERIOD, "R1", "soc spacing",
                  cyc - prev_soc, PERIOD);
          else
            check(cyc == 1, "R8", "first soc cycle", cyc, 1);
          prev_soc = cyc;
          periods++;
          if (measuring) close_period();
          if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            measuring = 1'b1;
            idx = 0;
            a_bad = -1;
            b_bad = -1;
          end else begin
            measuring = 1'b0;
          end
        end
        if (measuring) begin
          if (leg_a_o !== ((idx < cur.duty) ? 1'b1 : 1'b0) && a_bad < 0) begin
            a_bad = idx;
            a_bad_val = int'(leg_a_o);
          end
          if (leg_b_o !== ~leg_a_o && b_bad < 0) b_bad = idx;
          idx++;
        end
      end
    end
  end

  initial begin
    exp_t e0;
    e0.duty = 512;
    e0.tag  = "R9";
    exp_q.push_back(e0);

    repeat (3) @(posedge clk);
    #1;
    check(leg_a_o === 1'b0, "R9", "leg A in reset", int'(leg_a_o), 0);
    check(leg_b_o === 1'b0, "R9", "leg B in reset", int'(leg_b_o), 0);
    check(soc_o === 1'b0, "R9", "soc in reset", int'(soc_o), 0);
    @(negedge clk);
    rst = 1'b0;

    // Period 0 runs at the reset duty; this write must not disturb it (R6).
    drive_period(1, 12'h400, 0, 12'h000, expect_duty('h400), "R6");
    drive_period(1, 12'h000, 0, 12'h000, expect_duty('h000), "R5");
    drive_period(1, 12'hFFF, 0, 12'h000, expect_duty('hFFF), "R4");
    drive_period(1, 12'h003, 0, 12'h000, expect_duty('h003), "R4");
    drive_period(1, 12'h007, 0, 12'h000, expect_duty('h007), "R4");
    drive_period(1, 12'h100, 1, 12'hABC, expect_duty('hABC), "R7");
    drive_period(0, 12'h000, 0, 12'h000, expect_duty('hABC), "R10");
    drive_period(1, 12'h801, 0, 12'h000, expect_duty('h801), "R4");

    wait_soc();
    wait_soc();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8", "unconsumed expectations", exp_q.size(), 0);
    check(periods >= 10, "R1", "periods observed", periods, 10);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule